// File: doc/BRIEF.md
# Packed Pixel SIMD ALU

This unit performs byte-lane arithmetic on 32-bit words that each hold four unsigned 8-bit pixels. It serves video and image kernels. One opcode picks the operation:

- saturating add or subtract per lane
- rounded average per lane
- extraction of an aligned 32-bit window from a 64-bit operand pair
- a sum-of-absolute-differences step for motion estimation

The sum-of-absolute-differences step adds each lane's absolute difference into a private 16-bit accumulator.

A caller presents two operands, an opcode and a byte offset, and raises `in_valid` for one cycle per operation. A new operation may start every cycle. The packed result and a matching `out_valid` pulse appear on the next clock edge. The four accumulators can always be read on `acc_q`, and a dedicated clear opcode empties them.

Top module: `pix4_alu`

## Requirements
- R1: Every cycle with `in_valid` high yields `out_valid` high on the next cycle only. `result` is a register that keeps its value in any cycle that follows one without `in_valid`.
- R2: Opcode 0 adds each byte of `opnd_a` to the same byte of `opnd_b` as unsigned values. Any sum above 255 gives 255. Lanes never carry into one another.
- R3: Opcode 1 subtracts each byte of `opnd_b` from the same byte of `opnd_a`. Any negative difference gives 0, independently per lane.
- R4: Opcode 2 returns (a + b + 1) >> 1 per byte lane, so an exact half rounds up.
- R5: Opcode 3 treats {`opnd_b`, `opnd_a`} as an eight-byte source, with byte 0 in `opnd_a[7:0]`. It returns source bytes `byte_off` through `byte_off`+3, and the lowest of these lands in `result[7:0]`.
- R6: Opcode 4 returns the per-lane absolute differences |a − b| packed as bytes. It adds each difference into that lane's accumulator. Lane i occupies `acc_q[16i+15:16i]`. An accumulator that would pass 0xFFFF stays at 0xFFFF.
- R7: Opcode 5 sets all four accumulators and `result` to zero.
- R8: Opcodes 6 and 7 produce a zero result and leave the accumulators unchanged. An accumulator changes only under opcode 4 or opcode 5.
- R9: While `rst_n` is low, `out_valid`, `result` and `acc_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request for this cycle |
| op | input | 3 | Opcode (0 add, 1 sub, 2 avg, 3 align, 4 SAD, 5 clear, 6/7 reserved) |
| byte_off | input | 2 | Starting byte for the alignment opcode |
| opnd_a | input | 32 | First packed operand, also the low word of the alignment pair |
| opnd_b | input | 32 | Second packed operand, also the high word of the alignment pair |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Packed four-byte result |
| acc_q | output | 64 | Four 16-bit SAD accumulators, lane 0 in the low bits |

## Verification
Every result and every accumulator update lands on the first rising edge after the cycle in which `in_valid` is high. The bench therefore drives each request on a falling edge and compares `out_valid`, `result` and `acc_q` at the next falling edge, which is exactly one register stage later. During back-to-back SAD runs, `in_valid` is held for N cycles. The accumulator is read one half-cycle after the N-th capturing edge, and its expected value is N times the lane difference, limited to 0xFFFF. Cycles without a request are sampled as well, to confirm that the result and the accumulators stay unchanged.

// File: rtl/pix4_pkg.sv
package pix4_pkg;
  localparam int PIX_W = 8;

  typedef enum logic [2:0] {
    OP_ADDC  = 3'd0,
    OP_SUBC  = 3'd1,
    OP_AVG   = 3'd2,
    OP_ALIGN = 3'd3,
    OP_SAD   = 3'd4,
    OP_CLR   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } pix_op_e;

  function automatic logic [PIX_W-1:0] clip_add(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PIX_W] ? {PIX_W{1'b1}} : s[PIX_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] clip_sub(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a < b) ? '0 : (a - b);
  endfunction

  function automatic logic [PIX_W-1:0] avg_up(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};
    return s[PIX_W:1];
  endfunction

  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a < b) ? (b - a) : (a - b);
  endfunction
endpackage

// File: rtl/pix4_lane.sv
module pix4_lane
  import pix4_pkg::*;
(
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [PIX_W-1:0] add_c,
  output logic [PIX_W-1:0] sub_c,
  output logic [PIX_W-1:0] avg_r,
  output logic [PIX_W-1:0] absd
);
  always_comb begin
    add_c = clip_add(a, b);
    sub_c = clip_sub(a, b);
    avg_r = avg_up(a, b);
    absd  = abs_diff(a, b);
  end
endmodule

// File: rtl/pix4_align.sv
module pix4_align
  import pix4_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2*LANES*PIX_W-1:0] pair,
  input  logic [$clog2(LANES)-1:0] off,
  output logic [LANES*PIX_W-1:0]   win
);
  localparam int NB = 2 * LANES;
  localparam int IW = $clog2(NB);

  logic [PIX_W-1:0] src [NB];

  for (genvar k = 0; k < NB; k++) begin : g_src
    assign src[k] = pair[k*PIX_W +: PIX_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_win
    logic [IW-1:0] idx;
    assign idx = IW'(i) + IW'(off);
    assign win[i*PIX_W +: PIX_W] = src[idx];
  end
endmodule

// File: rtl/pix4_sad_acc.sv
module pix4_sad_acc
  import pix4_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PIX_W-1:0] diff,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W:0] sum;
  assign sum = {1'b0, acc} + (ACC_W+1)'(diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/pix4_alu.sv
module pix4_alu
  import pix4_pkg::*;
#(
  parameter int LANES = 4,
  parameter int ACC_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [2:0]                 op,
  input  logic [$clog2(LANES)-1:0]   byte_off,
  input  logic [LANES*PIX_W-1:0]     opnd_a,
  input  logic [LANES*PIX_W-1:0]     opnd_b,
  output logic                       out_valid,
  output logic [LANES*PIX_W-1:0]     result,
  output logic [LANES*ACC_W-1:0]     acc_q
);
  localparam int WW = LANES * PIX_W;

  pix_op_e         op_e;
  logic [WW-1:0]   add_w, sub_w, avg_w, abs_w, aln_w;
  logic [WW-1:0]   res_d;
  logic            sad_go, clr_go;

  assign op_e   = pix_op_e'(op);
  assign sad_go = in_valid && (op_e == OP_SAD);
  assign clr_go = in_valid && (op_e == OP_CLR);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pix4_lane u_lane (
      .a     (opnd_a[i*PIX_W +: PIX_W]),
      .b     (opnd_b[i*PIX_W +: PIX_W]),
      .add_c (add_w[i*PIX_W +: PIX_W]),
      .sub_c (sub_w[i*PIX_W +: PIX_W]),
      .avg_r (avg_w[i*PIX_W +: PIX_W]),
      .absd  (abs_w[i*PIX_W +: PIX_W])
    );

    pix4_sad_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_go),
      .en    (sad_go),
      .diff  (abs_w[i*PIX_W +: PIX_W]),
      .acc   (acc_q[i*ACC_W +: ACC_W])
    );
  end

  pix4_align #(.LANES(LANES)) u_align (
    .pair (opnd_b_a_pair()),
    .off  (byte_off),
    .win  (aln_w)
  );

  function automatic logic [2*WW-1:0] opnd_b_a_pair();
    return {opnd_b, opnd_a};
  endfunction

  always_comb begin
    unique case (op_e)
      OP_ADDC:  res_d = add_w;
      OP_SUBC:  res_d = sub_w;
      OP_AVG:   res_d = avg_w;
      OP_ALIGN: res_d = aln_w;
      OP_SAD:   res_d = abs_w;
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_d;
    end
  end
endmodule

// File: rtl/pix4_alu_chk.sv
module pix4_alu_chk
  import pix4_pkg::*;
#(
  parameter int LANES = 4,
  parameter int ACC_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [2:0]               op,
  input logic                     out_valid,
  input logic [LANES*PIX_W-1:0]   result,
  input logic [LANES*ACC_W-1:0]   acc_q
);
  // R1: valid pulse one cycle behind the request
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R1: result held across idle cycles
  a_r1_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R7: clear empties accumulators and result
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5) |=> (acc_q == '0 && result == '0));

  // R8: accumulators move only on SAD or clear
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || (op != 3'd4 && op != 3'd5)) |=> $stable(acc_q));

  // R6: a SAD step never lowers any lane
  for (genvar i = 0; i < LANES; i++) begin : g_mono
    a_r6_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd4) |=> acc_q[i*ACC_W +: ACC_W] >= $past(acc_q[i*ACC_W +: ACC_W]));
  end
endmodule

bind pix4_alu pix4_alu_chk #(.LANES(LANES), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .out_valid (out_valid),
  .result    (result),
  .acc_q     (acc_q)
);

// File: tb/tb_pix4_alu.sv
`timescale 1ns/1ps
module tb_pix4_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  byte_off = 2'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [63:0] acc_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pix4_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_off(byte_off),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result), .acc_q(acc_q)
  );

  // {op[3], off[2], a[32], b[32], expected[32]}
  localparam int NV = 10;
  localparam logic [100:0] VEC [NV] = '{
    {3'd0, 2'd0, 32'h10F080FF, 32'h20208001, 32'h30FFFFFF},
    {3'd0, 2'd2, 32'h01020304, 32'h05060708, 32'h06080A0C},
    {3'd1, 2'd0, 32'h1005FF00, 32'h08100101, 32'h0800FE00},
    {3'd2, 2'd0, 32'h01FF0003, 32'h02FF0004, 32'h02FF0004},
    {3'd2, 2'd1, 32'h00000000, 32'h01010101, 32'h01010101},
    {3'd3, 2'd0, 32'h33221100, 32'h77665544, 32'h33221100},
    {3'd3, 2'd1, 32'h33221100, 32'h77665544, 32'h44332211},
    {3'd3, 2'd2, 32'h33221100, 32'h77665544, 32'h55443322},
    {3'd3, 2'd3, 32'h33221100, 32'h77665544, 32'h66554433},
    {3'd1, 2'd3, 32'h00000080, 32'hFF0000FF, 32'h00000000}
  };

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on a falling edge, check one cycle later on the next falling edge
  task automatic issue(input logic [2:0] o, input logic [1:0] off, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; op = o; byte_off = off; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] acc_before;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 result", {32'd0, result}, 64'd0);
    chk("R9 acc", acc_q, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][100:98], VEC[i][97:96], VEC[i][95:64], VEC[i][63:32]);
      chk(tag_of(VEC[i][100:98]), {32'd0, result}, {32'd0, VEC[i][31:0]});
      chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
    end

    // R1 idle cycle: valid drops, result held
    @(negedge clk);
    chk("R1 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R1 idle hold", {32'd0, result}, {32'd0, VEC[NV-1][31:0]});

    // R6 SAD accumulate twice
    issue(3'd4, 2'd0, 32'h0A00FF05, 32'h03100005);
    chk("R6 absdiff", {32'd0, result}, 64'h0000_0000_0710_FF00);
    chk("R6 acc step1", acc_q, 64'h0007_0010_00FF_0000);
    issue(3'd4, 2'd0, 32'h0A00FF05, 32'h03100005);
    chk("R6 acc step2", acc_q, 64'h000E_0020_01FE_0000);

    // R8 reserved opcodes: zero result, acc unchanged
    acc_before = acc_q;
    issue(3'd6, 2'd1, 32'hFFFFFFFF, 32'h00000000);
    chk("R8 op6 result", {32'd0, result}, 64'd0);
    chk("R8 op6 acc", acc_q, acc_before);
    issue(3'd7, 2'd0, 32'h12345678, 32'h9ABCDEF0);
    chk("R8 op7 acc", acc_q, acc_before);
    issue(3'd0, 2'd0, 32'hFF000000, 32'h00000000);
    chk("R8 add acc", acc_q, acc_before);

    // R7 clear
    issue(3'd5, 2'd0, 32'h11111111, 32'h22222222);
    chk("R7 acc", acc_q, 64'd0);
    chk("R7 result", {32'd0, result}, 64'd0);

    // R6 saturation: 257 x 255 = 65535, then one more stays there
    @(negedge clk);
    in_valid = 1'b1; op = 3'd4; opnd_a = 32'h000000FF; opnd_b = 32'h0;
    repeat (256) @(negedge clk);
    chk("R6 before sat", acc_q, 64'h0000_0000_0000_FF00);
    @(negedge clk);
    chk("R6 at max", acc_q, 64'h0000_0000_0000_FFFF);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 saturated", acc_q, 64'h0000_0000_0000_FFFF);

    // R9 mid-run reset
    issue(3'd0, 2'd0, 32'h01010101, 32'h01010101);
    rst_n = 1'b0;
    #1;
    chk("R9 async result", {32'd0, result}, 64'd0);
    chk("R9 async acc", acc_q, 64'd0);
    @(negedge clk);
    chk("R9 async valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule